// File: doc/BRIEF.md
# GPIO Change-Detect Interrupt Unit

This block is the input-capture and interrupt core of a 16-pin port expander. The pins are split into two 8-pin ports. Each pin has three settings, all supplied by the surrounding register file: a direction bit, where 1 means input, an inversion bit, and the pin level itself. The pin levels pass through a two-stage synchronizer. The block keeps a reference snapshot of the synchronized levels. It raises an active-low, open-drain style interrupt when any input pin no longer matches its snapshot. It compares levels against the snapshot and does not detect edges. A rise and a fall therefore count the same, and a pin that returns to its reference clears its own request.

A one-cycle read strobe, with a port index, stands in for the serial bus. Each read does three things for the selected port. It returns the pin values, with inversion applied to input pins. It copies the synchronized levels into that port's snapshot. It drops that port's share of the pending interrupt. After reset the block spends a short priming period loading the snapshot from the pins, so no interrupt is pending when normal operation begins.

Top module: `pinwatch_irq`

## Requirements
- R1: The interrupt asserts when an input pin's level departs from its reference, for a rise or a fall alike. Asserted means `irq_n_o`=0 and `irq_oe_o`=1. A pin change driven before clock edge k shows at the output after edge k+2.
- R2: A pin whose direction bit is 0 (output) never causes an interrupt, whatever its level does.
- R3: The interrupt releases by itself, on the third edge after the revert, when every pin that caused it returns to its reference level before any read.
- R4: While the interrupt is pending, changes on other pins do not join it. Once the original causes are gone, any mismatch still present raises the interrupt again on the next edge.
- R5: A read strobe with `rd_port_i`=0 selects pins 7:0, and `rd_port_i`=1 selects pins 15:8. One edge after the strobe, `rd_vld_o` is 1 and `rd_data_o` holds the synchronized levels. Each bit is XOR'ed with its inversion bit for input pins and returned raw for output pins.
- R6: A read makes the present levels of its port that port's new reference and clears the pending bits of that port. Pending bits of the other port stay.
- R7: While reset is held, and for the first three edges after it is released, no interrupt is driven. After that, the reference equals the pin levels present at release.
- R8: Switching a pin from output to input while its level differs from the stored reference raises the interrupt one edge later. A read of that port clears it.
- R9: Inversion bits change only the read data. The interrupt decision uses raw levels, and changing inversion bits alone never raises or clears the interrupt.
- R10: A read strobe in the same cycle that a mismatch first appears has two effects. Mismatches on the read port are absorbed into the new reference without an interrupt. Mismatches on the other port still raise the interrupt at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 16 | Raw external pin levels |
| dir_in_i | input | 16 | Per-pin direction, 1 = input |
| inv_i | input | 16 | Per-pin readback inversion |
| rd_stb_i | input | 1 | One-cycle read request |
| rd_port_i | input | 1 | Port index for the read |
| rd_data_o | output | 8 | Read data of the selected port |
| rd_vld_o | output | 1 | Read data valid, one edge after strobe |
| irq_n_o | output | 1 | Interrupt level, 0 when pending |
| irq_oe_o | output | 1 | Pull-down enable for the open-drain pad |

## Verification
Two functions can act in the same cycle: a port read, which refreshes the snapshot and clears that port, and the capture of a fresh mismatch into the pending state. The bench changes a pin on each port together. It times the read strobe for the exact cycle in which the synchronized change first meets the comparator. It then judges that the read port's change is absorbed with no interrupt, while the other port's change pulls the interrupt low on that same edge. A second case reads port 0 while port 1 still holds a pending request, and confirms the interrupt stays low.

// File: rtl/pinwatch_pkg.sv
package pinwatch_pkg;

  // Readback of one port: inversion applies only to input-configured pins.
  function automatic logic [7:0] apply_inv8(input logic [7:0] lvl,
                                            input logic [7:0] is_in,
                                            input logic [7:0] inv);
    return lvl ^ (inv & is_in);
  endfunction

endpackage

// File: rtl/pinwatch_sync.sv
module pinwatch_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        stg_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        stg_q[s] <= stg_d[s];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pinwatch_slice.sv
module pinwatch_slice
  import pinwatch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         prime_i,
  input  logic         hold_i,
  input  logic         clr_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] inv_i,
  output logic [W-1:0] cause_o,
  output logic [W-1:0] miss_o,
  output logic [W-1:0] rdval_o
);

  logic [W-1:0] snap_q, snap_d;
  logic [W-1:0] cause_q, cause_d;
  logic         snap_en;

  assign miss_o  = (lvl_i ^ snap_q) & dir_i;
  assign snap_en = prime_i | clr_i;

  always_comb begin
    snap_d = snap_en ? lvl_i : snap_q;
    if (prime_i || clr_i) begin
      cause_d = '0;
    end else if (hold_i) begin
      cause_d = cause_q & miss_o;
    end else begin
      cause_d = miss_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      cause_q <= '0;
    end else begin
      snap_q  <= snap_d;
      cause_q <= cause_d;
    end
  end

  assign cause_o = cause_q;
  assign rdval_o = apply_inv8(8'(lvl_i), 8'(dir_i), 8'(inv_i))[W-1:0];

endmodule

// File: rtl/pinwatch_irq.sv
module pinwatch_irq #(
  parameter int  PORT_W      = 8,
  parameter int  NUM_PORTS   = 2,
  parameter int  SYNC_STAGES = 2,
  localparam int NPINS       = PORT_W * NUM_PORTS,
  localparam int PIDX_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [NPINS-1:0]  dir_in_i,
  input  logic [NPINS-1:0]  inv_i,
  input  logic              rd_stb_i,
  input  logic [PIDX_W-1:0] rd_port_i,
  output logic [PORT_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              irq_n_o,
  output logic              irq_oe_o
);

  localparam int PRIME_N = SYNC_STAGES + 1;
  localparam int CNT_W   = $clog2(PRIME_N + 1);

  logic [NPINS-1:0]                  lvl_w;
  logic [NPINS-1:0]                  cause_w;
  logic [NPINS-1:0]                  miss_w;
  logic [NUM_PORTS-1:0][PORT_W-1:0]  rdval_w;
  logic [CNT_W-1:0]                  prime_cnt_q, prime_cnt_d;
  logic                              prime_w;
  logic                              hold_w;
  logic [PORT_W-1:0]                 rd_data_q, rd_data_d;
  logic                              rd_vld_q;

  pinwatch_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (lvl_w)
  );

  // Priming: snapshot follows the synchronizer until it holds real pin data.
  assign prime_w = (prime_cnt_q != CNT_W'(PRIME_N));
  assign hold_w  = |cause_w;

  always_comb begin
    prime_cnt_d = prime_w ? prime_cnt_q + 1'b1 : prime_cnt_q;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic clr_w;
    assign clr_w = rd_stb_i && (rd_port_i == PIDX_W'(p));

    pinwatch_slice #(.W(PORT_W)) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .prime_i (prime_w),
      .hold_i  (hold_w),
      .clr_i   (clr_w),
      .lvl_i   (lvl_w[p*PORT_W +: PORT_W]),
      .dir_i   (dir_in_i[p*PORT_W +: PORT_W]),
      .inv_i   (inv_i[p*PORT_W +: PORT_W]),
      .cause_o (cause_w[p*PORT_W +: PORT_W]),
      .miss_o  (miss_w[p*PORT_W +: PORT_W]),
      .rdval_o (rdval_w[p])
    );
  end

  always_comb begin
    rd_data_d = rd_stb_i ? rdval_w[rd_port_i] : rd_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_cnt_q <= '0;
      rd_data_q   <= '0;
      rd_vld_q    <= 1'b0;
    end else begin
      prime_cnt_q <= prime_cnt_d;
      rd_data_q   <= rd_data_d;
      rd_vld_q    <= rd_stb_i;
    end
  end

  assign rd_data_o = rd_data_q;
  assign rd_vld_o  = rd_vld_q;
  assign irq_oe_o  = hold_w;
  assign irq_n_o   = ~hold_w;

endmodule

// File: rtl/pinwatch_chk.sv
module pinwatch_chk #(
  parameter int NPINS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prime,
  input logic [NPINS-1:0] cause,
  input logic [NPINS-1:0] miss,
  input logic [NPINS-1:0] dir_in,
  input logic             rd_stb,
  input logic             rd_vld,
  input logic             irq_oe
);

  AST_RISE_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_oe) |-> $past(|miss)); // R1

  AST_OUT_PIN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause & ~$past(dir_in)) == '0)); // R2

  AST_SELF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_oe) |-> ($past(rd_stb) || ($past(cause & miss) == '0))); // R3

  AST_HOLD_NO_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_oe && !rd_stb) |=> ((cause & ~$past(cause)) == '0)); // R4

  AST_READ_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_vld); // R5

  AST_PRIME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    prime |=> !irq_oe); // R7

endmodule

bind pinwatch_irq pinwatch_chk #(.NPINS(NPINS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .prime  (prime_w),
  .cause  (cause_w),
  .miss   (miss_w),
  .dir_in (dir_in_i),
  .rd_stb (rd_stb_i),
  .rd_vld (rd_vld_o),
  .irq_oe (irq_oe_o)
);

// File: tb/tb_pinwatch_irq.sv
module tb_pinwatch_irq;

  logic        clk;
  logic        rst_n;
  logic [15:0] pin;
  logic [15:0] dir_in;
  logic [15:0] inv;
  logic        rd_stb;
  logic [0:0]  rd_port;
  logic [7:0]  rd_data;
  logic        rd_vld;
  logic        irq_n;
  logic        irq_oe;

  int n_vec;
  int n_bad;
  int cyc;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  pinwatch_irq dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin),
    .dir_in_i  (dir_in),
    .inv_i     (inv),
    .rd_stb_i  (rd_stb),
    .rd_port_i (rd_port),
    .rd_data_o (rd_data),
    .rd_vld_o  (rd_vld),
    .irq_n_o   (irq_n),
    .irq_oe_o  (irq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Monitor: pops expected read data as the design delivers it.
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s: unexpected read data %h, expected none", "R5", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s: read data %h, expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic p, input logic [7:0] e, input string t);
    @(negedge clk);
    rd_stb  = 1'b1;
    rd_port = p;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic chk_irq(input logic want_low, input string t);
    n_vec++;
    if (irq_n !== ~want_low || irq_oe !== want_low) begin
      n_bad++;
      $display("FAIL %s: irq_n=%b irq_oe=%b, expected irq_n=%b irq_oe=%b",
               t, irq_n, irq_oe, ~want_low, want_low);
    end
  endtask

  task automatic finish_run();
    edges(2);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: %0d reads not returned, expected 0", "R5", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL %s: watchdog at cycle %0d, expected end before 20000", "ALL", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    n_vec   = 0;
    n_bad   = 0;
    rst_n   = 1'b0;
    pin     = 16'hA5C3;
    dir_in  = 16'hFFFF;
    inv     = 16'h0000;
    rd_stb  = 1'b0;
    rd_port = 1'b0;
    edges(3);
    chk_irq(1'b0, "R7 in reset");
    rst_n = 1'b1;
    edges(2);
    chk_irq(1'b0, "R7 priming");
    edges(2);
    chk_irq(1'b0, "R7 after priming");
    do_read(1'b0, 8'hC3, "R5 port0");
    do_read(1'b1, 8'hA5, "R5 port1");

    // R1 falling change on pin0
    pin[0] = 1'b0;
    edges(2);
    chk_irq(1'b0, "R1 not before third edge");
    edges(1);
    chk_irq(1'b1, "R1 fall");
    do_read(1'b0, 8'hC2, "R6 read clears");
    chk_irq(1'b0, "R6 cleared");

    // R1 rising on pin2, then R3 revert
    pin[2] = 1'b1;
    edges(3);
    chk_irq(1'b1, "R1 rise");
    pin[2] = 1'b0;
    edges(3);
    chk_irq(1'b0, "R3 revert");

    // R4 hold against other pins
    pin[9] = 1'b1;
    edges(3);
    chk_irq(1'b1, "R4 first cause");
    pin[4] = 1'b1;
    edges(3);
    chk_irq(1'b1, "R4 held");
    pin[9] = 1'b0;
    edges(3);
    chk_irq(1'b0, "R4 cause gone");
    edges(1);
    chk_irq(1'b1, "R4 retrigger");
    do_read(1'b0, 8'hD2, "R6 port0");
    edges(3);
    chk_irq(1'b0, "R6 stays clear");

    // R6 per-port clear
    pin[15] = 1'b0;
    edges(3);
    chk_irq(1'b1, "R6 port1 pending");
    do_read(1'b0, 8'hD2, "R6 other port read");
    chk_irq(1'b1, "R6 other port kept");
    do_read(1'b1, 8'h25, "R6 port1");
    chk_irq(1'b0, "R6 port1 cleared");

    // R2 output pins ignored
    dir_in = 16'hFFF7;
    pin[3] = 1'b1;
    edges(4);
    chk_irq(1'b0, "R2 output rise");
    do_read(1'b0, 8'hDA, "R5 output raw");
    pin[3] = 1'b0;
    edges(4);
    chk_irq(1'b0, "R2 output fall");

    // R8 output to input with stale reference
    dir_in = 16'hFFFF;
    edges(1);
    chk_irq(1'b1, "R8 spurious");
    do_read(1'b0, 8'hD2, "R8 clear read");
    chk_irq(1'b0, "R8 cleared");

    // R9 inversion only on readback
    dir_in = 16'hFFF7;
    inv    = 16'h00FF;
    edges(2);
    chk_irq(1'b0, "R9 inv alone");
    do_read(1'b0, 8'h25, "R5 inverted inputs");
    pin[1] = 1'b0;
    edges(3);
    chk_irq(1'b1, "R9 raw compare");
    do_read(1'b0, 8'h27, "R9 inverted read");
    chk_irq(1'b0, "R9 cleared");

    // R10 read in the cycle a mismatch first appears
    pin[0] = 1'b1;
    pin[8] = 1'b0;
    edges(1);
    do_read(1'b0, 8'h26, "R10 absorbed read");
    chk_irq(1'b1, "R10 other port raised");
    do_read(1'b1, 8'h24, "R10 port1");
    chk_irq(1'b0, "R10 cleared");
    edges(3);
    chk_irq(1'b0, "R10 absorbed stays quiet");

    finish_run();
  end

endmodule